// File: doc/BRIEF.md
# Two-Output Compare Waveform Timer

This block is one counter channel of a timer. A counter of parameterised width (32 bits by default) advances once per clock while the channel is enabled and not stopped. Three compare values watch the counter. Value A shapes output A, value B shapes output B, and value C sets the period and may act on both outputs. Each output keeps its own level. Any event that hits that output can set it, clear it or toggle it, and the effect is chosen per event by a 2-bit action code.

The counter runs in one of four waveform modes. It can count upward and wrap, count upward and restart after C, bounce between zero and all-ones, or bounce between zero and C. A software trigger pulse restarts the count from zero going upward. An external event can do the same when enabled. The event is picked from a small set of input lines and qualified by a chosen edge. A C match can also freeze the counter or drop the enable. Sticky status flags record compare matches and clear when they are read.

Top module: `wavegen_chan`

## Requirements
- R1: After a synchronous reset, both outputs are low, the count is 0, the channel is disabled and not running, and all status flags are 0.
- R2: A start pulse enables the channel. A halt pulse disables it, and halt wins when both arrive together. While running, the count advances by one per clock. While not running, and with no trigger, it holds its value.
- R3: Mode field coding: 0 counts up and wraps from all-ones to 0. 2 counts up and goes to 0 on the clock after the count equals C.
- R4: Mode 1 counts up to all-ones, then down to 0, then up again. Each turning value is held for one clock.
- R5: Mode 3 counts up to C, then down to 0, then up again.
- R6: Action coding is 0 none, 1 set, 2 clear, 3 toggle. Compare A acts on output A, compare B on output B, and compare C on both, each with its own code. An output changes on the clock after the running count equals the compare value.
- R7: When several events hit one output in the same clock, the highest-priority event whose code is not none wins. The order from highest is software trigger, external event, compare C, then compare A or B.
- R8: A software trigger sets the count to 0 on the next clock and makes counting upward. It also clears a stop caused by C. It does not enable a disabled channel.
- R9: The event line is chosen by a 2-bit index into the event lines. Edge coding is 0 none, 1 rising, 2 falling, 3 both. An accepted edge applies its output actions. It zeroes the count only when the event-restart input is 1.
- R10: With stop-at-C set, a C match freezes the count at C and running falls while enabled stays 1. With halt-at-C set, a C match freezes the count and clears enabled.
- R11: Status bit 0 records compare A, bit 1 compare B and bit 2 compare C. A read pulse clears them, but a match in the same clock as the read keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Enable pulse |
| cmd_halt | input | 1 | Disable pulse |
| cmd_swtrig | input | 1 | Software trigger pulse |
| wave_mode | input | 2 | Counting mode |
| cmp_a_val | input | CW | Compare value A |
| cmp_b_val | input | CW | Compare value B |
| cmp_c_val | input | CW | Compare value C (period) |
| act_a_cmpa | input | 2 | Compare A action on output A |
| act_a_cmpc | input | 2 | Compare C action on output A |
| act_a_evt | input | 2 | External event action on output A |
| act_a_sw | input | 2 | Software trigger action on output A |
| act_b_cmpb | input | 2 | Compare B action on output B |
| act_b_cmpc | input | 2 | Compare C action on output B |
| act_b_evt | input | 2 | External event action on output B |
| act_b_sw | input | 2 | Software trigger action on output B |
| stop_at_c | input | 1 | Freeze on C match |
| halt_at_c | input | 1 | Disable on C match |
| evt_sel | input | SELW | Event line index |
| evt_edge | input | 2 | Event edge selection |
| evt_restart | input | 1 | Event also zeroes the count |
| evt_lines | input | NLINES | Event source lines |
| stat_rd | input | 1 | Status read pulse (clears flags) |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CW | Counter value |
| clk_enabled | output | 1 | Channel enabled |
| running | output | 1 | Enabled and not frozen |
| stat_cmp | output | 3 | Sticky compare flags |

## Verification
The assertions assume that all inputs are synchronous to the clock. They also assume that the command and read inputs are single-clock pulses and that the configuration holds still while a check depends on it. The stimulus follows these rules by driving every input on the falling edge. It changes mode, compare values and action codes only while the channel is halted, or at the moment a new run begins. The bench uses an 8-bit counter so that the turn at all-ones and the wrap to zero both fall within a short run.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_t;

  typedef enum logic [1:0] {
    WM_UP      = 2'd0,
    WM_UPDN    = 2'd1,
    WM_UP_RC   = 2'd2,
    WM_UPDN_RC = 2'd3
  } wmode_t;

  typedef enum logic [1:0] {
    EDG_NONE = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_t;

  // event sources per output, index 0 has the highest priority
  localparam int NUM_SRC  = 4;
  localparam int SRC_SW   = 0;
  localparam int SRC_EVT  = 1;
  localparam int SRC_CMPC = 2;
  localparam int SRC_CMPX = 3;

  function automatic logic apply_act(input act_t a, input logic q);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~q;
      default: return q;
    endcase
  endfunction

endpackage

// File: rtl/wg_evt_detect.sv
`timescale 1ns/1ps
module wg_evt_detect
  import wg_pkg::*;
#(
  parameter int NLINES = 4,
  localparam int SELW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] lines,
  input  logic [SELW-1:0]   sel,
  input  logic [1:0]        edge_mode,
  output logic              evt
);

  // every line is delayed, so switching the index makes no false edge
  logic [NLINES-1:0] prev_q;
  logic cur_l, old_l;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lines;
  end

  assign cur_l = lines[sel];
  assign old_l = prev_q[sel];

  always_comb begin
    case (edge_t'(edge_mode))
      EDG_RISE: evt = cur_l & ~old_l;
      EDG_FALL: evt = ~cur_l & old_l;
      EDG_BOTH: evt = cur_l ^ old_l;
      default:  evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/wg_counter.sv
`timescale 1ns/1ps
module wg_counter
  import wg_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic          cmd_halt,
  input  logic          trig,
  input  logic [1:0]    wave_mode,
  input  logic [CW-1:0] cmp_c,
  input  logic          stop_at_c,
  input  logic          halt_at_c,
  output logic [CW-1:0] cnt_q,
  output logic          clk_on_q,
  output logic          run,
  output logic          hit_c
);

  localparam logic [CW-1:0] CNT_TOP  = '1;
  localparam logic [CW-1:0] CNT_ZERO = '0;
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          stopped_q;
  logic          down_q;
  logic [CW-1:0] cnt_nxt;
  logic          down_nxt;
  logic          freeze;
  logic          at_top;

  assign run    = clk_on_q & ~stopped_q;
  assign hit_c  = run && (cnt_q == cmp_c);
  assign freeze = hit_c && (stop_at_c || halt_at_c);

  always_comb begin
    cnt_nxt  = cnt_q + CNT_ONE;
    down_nxt = 1'b0;
    at_top   = 1'b0;
    case (wmode_t'(wave_mode))
      WM_UP: begin
        cnt_nxt = cnt_q + CNT_ONE;
      end
      WM_UP_RC: begin
        cnt_nxt = (cnt_q == cmp_c) ? CNT_ZERO : cnt_q + CNT_ONE;
      end
      WM_UPDN, WM_UPDN_RC: begin
        if (wmode_t'(wave_mode) == WM_UPDN_RC)
          at_top = (cnt_q == cmp_c) || (cnt_q == CNT_TOP);
        else
          at_top = (cnt_q == CNT_TOP);
        if (!down_q) begin
          if (at_top && cnt_q == CNT_ZERO) begin
            cnt_nxt  = CNT_ZERO;
            down_nxt = 1'b0;
          end else if (at_top) begin
            cnt_nxt  = cnt_q - CNT_ONE;
            down_nxt = 1'b1;
          end else begin
            cnt_nxt  = cnt_q + CNT_ONE;
            down_nxt = 1'b0;
          end
        end else begin
          if (cnt_q == CNT_ZERO) begin
            cnt_nxt  = CNT_ONE;
            down_nxt = 1'b0;
          end else begin
            cnt_nxt  = cnt_q - CNT_ONE;
            down_nxt = 1'b1;
          end
        end
      end
      default: begin
        cnt_nxt  = cnt_q + CNT_ONE;
        down_nxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      down_q    <= 1'b0;
      clk_on_q  <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      if (cmd_halt)       clk_on_q <= 1'b0;
      else if (cmd_start) clk_on_q <= 1'b1;
      if (hit_c && halt_at_c) clk_on_q <= 1'b0;

      if (trig) begin
        cnt_q     <= '0;
        down_q    <= 1'b0;
        stopped_q <= 1'b0;
      end else if (freeze) begin
        if (stop_at_c) stopped_q <= 1'b1;
      end else if (run) begin
        cnt_q  <= cnt_nxt;
        down_q <= down_nxt;
      end
    end
  end

endmodule

// File: rtl/wg_out_ctl.sv
`timescale 1ns/1ps
module wg_out_ctl
  import wg_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      hit,
  input  logic [NSRC-1:0][1:0] act,
  output logic                 q
);

  act_t win;

  // scan from lowest priority up so the highest active source overrides
  always_comb begin
    win = ACT_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i] && act[i] != 2'd0) win = act_t'(act[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= apply_act(win, q);
  end

endmodule

// File: rtl/wg_status.sv
`timescale 1ns/1ps
module wg_status #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_in,
  input  logic             rd,
  output logic [NFLAG-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= set_in | (flags_q & {NFLAG{~rd}});
  end

endmodule

// File: rtl/wavegen_chan.sv
`timescale 1ns/1ps
module wavegen_chan
  import wg_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NLINES = 4,
  localparam int SELW  = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_halt,
  input  logic              cmd_swtrig,
  input  logic [1:0]        wave_mode,
  input  logic [CW-1:0]     cmp_a_val,
  input  logic [CW-1:0]     cmp_b_val,
  input  logic [CW-1:0]     cmp_c_val,
  input  logic [1:0]        act_a_cmpa,
  input  logic [1:0]        act_a_cmpc,
  input  logic [1:0]        act_a_evt,
  input  logic [1:0]        act_a_sw,
  input  logic [1:0]        act_b_cmpb,
  input  logic [1:0]        act_b_cmpc,
  input  logic [1:0]        act_b_evt,
  input  logic [1:0]        act_b_sw,
  input  logic              stop_at_c,
  input  logic              halt_at_c,
  input  logic [SELW-1:0]   evt_sel,
  input  logic [1:0]        evt_edge,
  input  logic              evt_restart,
  input  logic [NLINES-1:0] evt_lines,
  input  logic              stat_rd,
  output logic              out_a,
  output logic              out_b,
  output logic [CW-1:0]     count,
  output logic              clk_enabled,
  output logic              running,
  output logic [2:0]        stat_cmp
);

  localparam int NOUT = 2;

  logic evt_hit;
  logic trig;
  logic run;
  logic hit_a, hit_b, hit_c;
  logic [NOUT-1:0] cmp_hit;
  logic [NOUT-1:0] wave_q;
  logic [NOUT-1:0][NUM_SRC-1:0][1:0] act_sel;

  wg_evt_detect #(.NLINES(NLINES)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .lines     (evt_lines),
    .sel       (evt_sel),
    .edge_mode (evt_edge),
    .evt       (evt_hit)
  );

  assign trig = cmd_swtrig | (evt_hit & evt_restart);

  wg_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .cmd_halt  (cmd_halt),
    .trig      (trig),
    .wave_mode (wave_mode),
    .cmp_c     (cmp_c_val),
    .stop_at_c (stop_at_c),
    .halt_at_c (halt_at_c),
    .cnt_q     (count),
    .clk_on_q  (clk_enabled),
    .run       (run),
    .hit_c     (hit_c)
  );

  assign running = run;
  assign hit_a   = run && (count == cmp_a_val);
  assign hit_b   = run && (count == cmp_b_val);
  assign cmp_hit = {hit_b, hit_a};

  // source order per output: [3] own compare, [2] compare C, [1] event, [0] software
  assign act_sel[0] = {act_a_cmpa, act_a_cmpc, act_a_evt, act_a_sw};
  assign act_sel[1] = {act_b_cmpb, act_b_cmpc, act_b_evt, act_b_sw};

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [NUM_SRC-1:0] src_hit;
    assign src_hit[SRC_SW]   = cmd_swtrig;
    assign src_hit[SRC_EVT]  = evt_hit;
    assign src_hit[SRC_CMPC] = hit_c;
    assign src_hit[SRC_CMPX] = cmp_hit[o];

    wg_out_ctl #(.NSRC(NUM_SRC)) u_out (
      .clk (clk),
      .rst (rst),
      .hit (src_hit),
      .act (act_sel[o]),
      .q   (wave_q[o])
    );
  end

  assign out_a = wave_q[0];
  assign out_b = wave_q[1];

  wg_status #(.NFLAG(3)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_in  ({hit_c, hit_b, hit_a}),
    .rd      (stat_rd),
    .flags_q (stat_cmp)
  );

endmodule

// File: rtl/wavegen_chan_chk.sv
`timescale 1ns/1ps
module wavegen_chan_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          trig,
  input logic          run,
  input logic [CW-1:0] count,
  input logic [1:0]    wave_mode,
  input logic [CW-1:0] cmp_c_val,
  input logic          stop_at_c,
  input logic          halt_at_c,
  input logic          cmd_halt,
  input logic          clk_enabled,
  input logic          stat_rd,
  input logic [2:0]    stat_cmp,
  input logic          hit_a,
  input logic          hit_b,
  input logic          hit_c,
  input logic          sw,
  input logic          evt_hit,
  input logic          out_a
);

  p_trig_zero_r8: assert property (@(posedge clk) disable iff (rst)
    trig |=> (count == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !trig) |=> (count == $past(count)));

  p_halt_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_halt |=> !clk_enabled);

  p_rc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !trig && wave_mode == 2'd2 && count == cmp_c_val && !stop_at_c && !halt_at_c)
      |=> (count == '0));

  p_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (hit_c && stop_at_c && !trig) |=> !run);

  p_rd_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !hit_a && !hit_b && !hit_c) |=> (stat_cmp == 3'b000));

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!sw && !evt_hit && !hit_a && !hit_c) |=> $stable(out_a));

endmodule

bind wavegen_chan wavegen_chan_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .trig        (trig),
  .run         (run),
  .count       (count),
  .wave_mode   (wave_mode),
  .cmp_c_val   (cmp_c_val),
  .stop_at_c   (stop_at_c),
  .halt_at_c   (halt_at_c),
  .cmd_halt    (cmd_halt),
  .clk_enabled (clk_enabled),
  .stat_rd     (stat_rd),
  .stat_cmp    (stat_cmp),
  .hit_a       (hit_a),
  .hit_b       (hit_b),
  .hit_c       (hit_c),
  .sw          (cmd_swtrig),
  .evt_hit     (evt_hit),
  .out_a       (out_a)
);

// File: tb/sim_wavegen_chan.sv
`timescale 1ns/1ps
module sim_wavegen_chan;

  localparam int CW = 8;
  localparam int NL = 4;

  localparam int K_CNT = 0;
  localparam int K_OA  = 1;
  localparam int K_OB  = 2;
  localparam int K_ST  = 3;
  localparam int K_EN  = 4;
  localparam int K_RUN = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic cmd_start, cmd_halt, cmd_swtrig;
  logic [1:0] wave_mode;
  logic [CW-1:0] cmp_a_val, cmp_b_val, cmp_c_val;
  logic [1:0] act_a_cmpa, act_a_cmpc, act_a_evt, act_a_sw;
  logic [1:0] act_b_cmpb, act_b_cmpc, act_b_evt, act_b_sw;
  logic stop_at_c, halt_at_c;
  logic [1:0] evt_sel, evt_edge;
  logic evt_restart;
  logic [NL-1:0] evt_lines;
  logic stat_rd;
  logic out_a, out_b, clk_enabled, running;
  logic [CW-1:0] count;
  logic [2:0] stat_cmp;

  wavegen_chan #(.CW(CW), .NLINES(NL)) u0 (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
    .cmd_swtrig(cmd_swtrig), .wave_mode(wave_mode),
    .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val), .cmp_c_val(cmp_c_val),
    .act_a_cmpa(act_a_cmpa), .act_a_cmpc(act_a_cmpc), .act_a_evt(act_a_evt),
    .act_a_sw(act_a_sw), .act_b_cmpb(act_b_cmpb), .act_b_cmpc(act_b_cmpc),
    .act_b_evt(act_b_evt), .act_b_sw(act_b_sw), .stop_at_c(stop_at_c),
    .halt_at_c(halt_at_c), .evt_sel(evt_sel), .evt_edge(evt_edge),
    .evt_restart(evt_restart), .evt_lines(evt_lines), .stat_rd(stat_rd),
    .out_a(out_a), .out_b(out_b), .count(count), .clk_enabled(clk_enabled),
    .running(running), .stat_cmp(stat_cmp)
  );

  typedef struct {
    int    at;
    int    kind;
    int    exp;
    string req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(int k);
    case (k)
      K_CNT:   return int'(count);
      K_OA:    return int'(out_a);
      K_OB:    return int'(out_b);
      K_ST:    return int'(stat_cmp);
      K_EN:    return int'(clk_enabled);
      default: return int'(running);
    endcase
  endfunction

  // monitor: compares queued expectations against the outputs
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        int got;
        got = observe(sb[i].kind);
        total++;
        if (got !== sb[i].exp) begin
          bad++;
          $display("FAIL %s kind=%0d cyc=%0d actual=%0d expected=%0d",
                   sb[i].req, sb[i].kind, cyc, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int dly, int kind, int v, string req);
    exp_t e;
    e.at = cyc + dly; e.kind = kind; e.exp = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic go();
    cmd_start = 1'b1; cmd_swtrig = 1'b1;
    tick(1);
    cmd_start = 1'b0; cmd_swtrig = 1'b0;
  endtask

  task automatic halt_ch();
    cmd_halt = 1'b1;
    tick(1);
    cmd_halt = 1'b0;
    tick(2);
  endtask

  task automatic defaults();
    wave_mode = 2'd0;
    cmp_a_val = 8'd200; cmp_b_val = 8'd201; cmp_c_val = 8'd202;
    act_a_cmpa = 2'd0; act_a_cmpc = 2'd0; act_a_evt = 2'd0; act_a_sw = 2'd2;
    act_b_cmpb = 2'd0; act_b_cmpc = 2'd0; act_b_evt = 2'd0; act_b_sw = 2'd2;
    stop_at_c = 1'b0; halt_at_c = 1'b0;
    evt_sel = 2'd0; evt_edge = 2'd0; evt_restart = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    cmd_start = 1'b0; cmd_halt = 1'b0; cmd_swtrig = 1'b0;
    evt_lines = '0; stat_rd = 1'b0;
    defaults();
    tick(4);
    rst = 1'b0;

    // R1 reset state
    expect_at(1, K_CNT, 0, "R1"); expect_at(1, K_OA, 0, "R1");
    expect_at(1, K_OB, 0, "R1");  expect_at(1, K_ST, 0, "R1");
    expect_at(1, K_EN, 0, "R1");  expect_at(1, K_RUN, 0, "R1");
    tick(3);

    // R3 mode 2, R6 actions, R2 counting and hold
    defaults();
    wave_mode = 2'd2; cmp_c_val = 8'd9; cmp_a_val = 8'd3; cmp_b_val = 8'd5;
    act_a_cmpa = 2'd1; act_a_cmpc = 2'd2; act_b_cmpb = 2'd3;
    tick(1);
    expect_at(6, K_CNT, 5, "R2");
    expect_at(10, K_CNT, 9, "R3"); expect_at(11, K_CNT, 0, "R3");
    expect_at(4, K_OA, 0, "R6");   expect_at(5, K_OA, 1, "R6");
    expect_at(10, K_OA, 1, "R6");  expect_at(11, K_OA, 0, "R6");
    expect_at(7, K_OB, 1, "R6");   expect_at(17, K_OB, 0, "R6");
    go();
    tick(20);
    expect_at(1, K_CNT, 1, "R2"); expect_at(5, K_CNT, 1, "R2");
    expect_at(1, K_EN, 0, "R2");  expect_at(1, K_RUN, 0, "R2");
    halt_ch();
    tick(3);
    expect_at(1, K_ST, 7, "R11");
    tick(1);
    stat_rd = 1'b1;
    expect_at(1, K_ST, 0, "R11");
    tick(1);
    stat_rd = 1'b0;
    tick(1);

    // R3 mode 0 wrap
    defaults();
    tick(1);
    expect_at(256, K_CNT, 255, "R3"); expect_at(257, K_CNT, 0, "R3");
    expect_at(258, K_CNT, 1, "R3");
    go(); tick(260); halt_ch();

    // R4 mode 1 bounce between all-ones and zero
    defaults(); wave_mode = 2'd1;
    tick(1);
    expect_at(256, K_CNT, 255, "R4"); expect_at(257, K_CNT, 254, "R4");
    expect_at(511, K_CNT, 0, "R4");   expect_at(512, K_CNT, 1, "R4");
    expect_at(513, K_CNT, 2, "R4");
    go(); tick(515); halt_ch();

    // R5 mode 3 bounce between C and zero, R8 trigger restarts upward
    defaults(); wave_mode = 2'd3; cmp_c_val = 8'd6; cmp_a_val = 8'd2;
    act_a_cmpa = 2'd3; act_b_cmpc = 2'd1;
    tick(1);
    expect_at(7, K_CNT, 6, "R5");  expect_at(8, K_CNT, 5, "R5");
    expect_at(13, K_CNT, 0, "R5"); expect_at(14, K_CNT, 1, "R5");
    expect_at(19, K_CNT, 6, "R5");
    expect_at(4, K_OA, 1, "R6");   expect_at(12, K_OA, 0, "R6");
    expect_at(16, K_OA, 1, "R6");
    expect_at(7, K_OB, 0, "R6");   expect_at(8, K_OB, 1, "R6");
    go(); tick(20);
    cmd_swtrig = 1'b1;
    expect_at(1, K_CNT, 0, "R8"); expect_at(2, K_CNT, 1, "R8");
    expect_at(3, K_CNT, 2, "R8"); expect_at(1, K_OA, 0, "R8");
    tick(1); cmd_swtrig = 1'b0;
    tick(4); halt_ch();

    // R10 stop at C, then halt at C
    defaults(); cmp_c_val = 8'd5; stop_at_c = 1'b1;
    tick(1);
    expect_at(6, K_CNT, 5, "R10");  expect_at(7, K_CNT, 5, "R10");
    expect_at(12, K_CNT, 5, "R10"); expect_at(6, K_RUN, 1, "R10");
    expect_at(7, K_RUN, 0, "R10");  expect_at(12, K_EN, 1, "R10");
    go(); tick(12);
    cmd_swtrig = 1'b1;
    expect_at(1, K_CNT, 0, "R8"); expect_at(1, K_RUN, 1, "R8");
    expect_at(3, K_CNT, 2, "R8");
    tick(1); cmd_swtrig = 1'b0;
    tick(8); halt_ch();
    stop_at_c = 1'b0; halt_at_c = 1'b1;
    tick(1);
    expect_at(6, K_CNT, 5, "R10"); expect_at(6, K_EN, 1, "R10");
    expect_at(7, K_EN, 0, "R10");  expect_at(10, K_CNT, 5, "R10");
    go(); tick(10);
    cmd_swtrig = 1'b1;
    expect_at(1, K_CNT, 0, "R8"); expect_at(2, K_RUN, 0, "R8");
    expect_at(3, K_CNT, 0, "R8");
    tick(1); cmd_swtrig = 1'b0;
    tick(3);

    // R7 priority
    defaults(); evt_sel = 2'd2; evt_edge = 2'd1;
    act_a_sw = 2'd1; act_a_evt = 2'd2;
    tick(1);
    evt_lines[2] = 1'b1; cmd_swtrig = 1'b1;
    expect_at(1, K_OA, 1, "R7");
    tick(1); evt_lines[2] = 1'b0; cmd_swtrig = 1'b0;
    tick(2);
    act_a_sw = 2'd0;
    tick(1);
    evt_lines[2] = 1'b1; cmd_swtrig = 1'b1;
    expect_at(1, K_OA, 0, "R7");
    tick(1); evt_lines[2] = 1'b0; cmd_swtrig = 1'b0;
    tick(2);
    defaults(); act_a_sw = 2'd0; cmp_a_val = 8'd4; cmp_c_val = 8'd4;
    act_a_cmpa = 2'd2; act_a_cmpc = 2'd1;
    tick(1);
    expect_at(5, K_OA, 0, "R7"); expect_at(6, K_OA, 1, "R7");
    go(); tick(8); halt_ch();

    // R9 external event
    defaults(); evt_sel = 2'd1; evt_edge = 2'd2; evt_restart = 1'b1;
    act_b_evt = 2'd3;
    tick(1);
    go(); tick(10);
    evt_lines[1] = 1'b1;
    expect_at(1, K_CNT, 11, "R9"); expect_at(1, K_OB, 0, "R9");
    tick(1);
    evt_lines[1] = 1'b0;
    expect_at(1, K_CNT, 0, "R9"); expect_at(3, K_CNT, 2, "R9");
    expect_at(1, K_OB, 1, "R9");
    tick(4);
    evt_sel = 2'd3; evt_edge = 2'd3; evt_lines[3] = 1'b1;
    expect_at(1, K_CNT, 0, "R9"); expect_at(1, K_OB, 0, "R9");
    tick(4);
    evt_lines[3] = 1'b0;
    expect_at(1, K_OB, 1, "R9");
    tick(2);
    evt_edge = 2'd0; evt_lines[3] = 1'b1;
    expect_at(1, K_OB, 1, "R9"); expect_at(2, K_OB, 1, "R9");
    tick(3);
    evt_lines[3] = 1'b0;
    halt_ch();

    // R11 read in the same clock as a match
    stat_rd = 1'b1;
    expect_at(1, K_ST, 0, "R11");
    tick(1); stat_rd = 1'b0;
    defaults(); wave_mode = 2'd2; cmp_c_val = 8'd3; cmp_a_val = 8'd1;
    tick(1);
    go(); tick(2);
    expect_at(1, K_ST, 1, "R11");
    tick(1);
    stat_rd = 1'b1;
    expect_at(1, K_ST, 4, "R11");
    tick(1); stat_rd = 1'b0;
    halt_ch();

    tick(4);
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R1 pending=%0d expected=0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule